// File: doc/BRIEF.md
# Self-Timed Nonvolatile Program Sequencer

This block carries out the programming cycles of a small word-organized nonvolatile store, modelled as an on-chip register array. A serial front end decodes instructions and hands each one over as a single command beat. The beat carries an opcode, an address and a data word. The sequencer then erases or programs the array on its own, one word per system clock during the whole-array operations. It holds `busy` for a fixed, per-command number of clock cycles. It also enforces a programming-enable lock. A separate read port returns any word at any time.

Commands arrive over a valid/ready interface. `cmd_ready` is low for as long as a cycle is running. The front end must keep `cmd_valid` and the command fields steady until it sees `cmd_ready` high at a clock edge. A beat presented while `cmd_ready` is low is not taken and has no effect. An accepted programming command, or the two lock commands, are consumed in that edge. A programming command that is accepted while programming is locked is consumed and dropped. The reset stands in for the supply lockout. It clears the lock and the sequencer state, but it leaves the array contents as they were.

Top module: `nvm_prog_seq`

## Requirements
- R1: After reset, programming is locked. An accepted erase (3), erase-all (4), write (5) or write-all (6) command then leaves `busy` low and the array unchanged, until an unlock command (opcode 1) is accepted.
- R2: Programming stays unlocked until a lock command (opcode 2) is accepted or reset is applied. After either one, programming commands are dropped again.
- R3: `rd_data` shows the word at the `rd_addr` value sampled at the previous clock edge. This holds in both lock states.
- R4: An erase of one word (opcode 3) sets the addressed word to all ones and leaves every other word unchanged.
- R5: Erase-all (opcode 4) sets every word of the array to all ones.
- R6: A single-word write (opcode 5) first erases the addressed word and then programs it. The final word equals `cmd_data` exactly, whatever the word held before.
- R7: Write-all (opcode 6) erases the whole array and then writes `cmd_data` into every word, with no separate erase-all command needed.
- R8: After an unlocked programming command is accepted, `busy` is high from the next cycle for exactly T_WORD cycles for opcodes 3 and 5, T_ALL cycles for opcode 4, and T_WRALL cycles for opcode 6. The lock commands never raise `busy`.
- R9: `cmd_ready` is the inverse of `busy`. A command presented while `busy` is high has no effect on the array or on the lock state.
- R10: Opcodes 0 and 7 are no-operations. All whole-array sweeps need T_ALL >= 2^AW and T_WRALL >= 2^(AW+1).
- R11: Reset does not alter the array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, power-on stand-in |
| cmd_valid | input | 1 | Command beat present |
| cmd_ready | output | 1 | Sequencer can take a command (idle) |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | AW | Word address for single-word commands |
| cmd_data | input | DW | Data word for write and write-all |
| busy | output | 1 | Programming cycle in progress (registered) |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Word read, one cycle after `rd_addr` |

## Verification
The properties assume that `cmd_op` is a known value whenever `cmd_valid` is high. They also assume that the lock state and the array write port move only because of accepted command beats. The stimulus respects this in two ways. All command traffic goes through one driver task, which raises `cmd_valid` shortly after a clock edge and drops it one edge later. Read addresses are changed only between edges, so every capture sees settled inputs. The same driver also presents a beat while a cycle runs, which exercises the refusal path on purpose rather than by accident.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PEN  = 3'd1,
    OP_PDIS = 3'd2,
    OP_ERW  = 3'd3,
    OP_ERA  = 3'd4,
    OP_WRW  = 3'd5,
    OP_WRA  = 3'd6,
    OP_RSV  = 3'd7
  } nvm_op_e;

  function automatic logic is_prog(input logic [2:0] op);
    return (op == OP_ERW) || (op == OP_ERA) || (op == OP_WRW) || (op == OP_WRA);
  endfunction
endpackage

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
  import nvm_prog_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int T_WORD  = 100,
  parameter int T_ALL   = 300,
  parameter int T_WRALL = 750,
  parameter int SW      = $clog2(T_WRALL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          busy,
  output logic          prog_en,
  output nvm_op_e       act_op,
  output logic [AW-1:0] act_addr,
  output logic [DW-1:0] act_data,
  output logic [SW-1:0] step
);
  localparam logic [SW-1:0] LAST_WORD = SW'(T_WORD - 1);
  localparam logic [SW-1:0] LAST_ALL  = SW'(T_ALL - 1);
  localparam logic [SW-1:0] LAST_WRA  = SW'(T_WRALL - 1);

  logic          accept;
  logic [SW-1:0] last_step;

  assign accept = cmd_valid && !busy;

  always_comb begin
    case (act_op)
      OP_ERA:  last_step = LAST_ALL;
      OP_WRA:  last_step = LAST_WRA;
      default: last_step = LAST_WORD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      prog_en  <= 1'b0;
      step     <= '0;
      act_op   <= OP_NOP;
      act_addr <= '0;
      act_data <= '0;
    end else if (accept) begin
      if (cmd_op == OP_PEN) begin
        prog_en <= 1'b1;
      end else if (cmd_op == OP_PDIS) begin
        prog_en <= 1'b0;
      end else if (is_prog(cmd_op) && prog_en) begin
        busy     <= 1'b1;
        step     <= '0;
        act_op   <= nvm_op_e'(cmd_op);
        act_addr <= cmd_addr;
        act_data <= cmd_data;
      end
    end else if (busy) begin
      if (step == last_step) begin
        busy <= 1'b0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/nvm_prog_wgen.sv
module nvm_prog_wgen
  import nvm_prog_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SW = 10
) (
  input  logic          busy,
  input  nvm_op_e       act_op,
  input  logic [AW-1:0] act_addr,
  input  logic [DW-1:0] act_data,
  input  logic [SW-1:0] step,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [DW-1:0] wdata
);
  localparam int NW = 1 << AW;
  localparam logic [DW-1:0] ONES = '1;

  int unsigned s;
  assign s = int'(step);

  always_comb begin
    we    = 1'b0;
    waddr = act_addr;
    wdata = ONES;
    if (busy) begin
      case (act_op)
        OP_ERW: we = (s == 0);
        OP_WRW: begin
          we    = (s < 2);
          wdata = (s == 0) ? ONES : act_data;
        end
        OP_ERA: begin
          we    = (s < NW);
          waddr = step[AW-1:0];
        end
        OP_WRA: begin
          we    = (s < 2 * NW);
          waddr = step[AW-1:0];
          wdata = (s < NW) ? ONES : act_data;
        end
        default: we = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/nvm_prog_array.sv
module nvm_prog_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int NW = 1 << AW;

  logic [DW-1:0] mem [NW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/nvm_prog_seq.sv
module nvm_prog_seq
  import nvm_prog_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int T_WORD  = 100,
  parameter int T_ALL   = 300,
  parameter int T_WRALL = 750
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  output logic          busy,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int SW = $clog2(T_WRALL + 1);

  logic          prog_en;
  nvm_op_e       act_op;
  logic [AW-1:0] act_addr;
  logic [DW-1:0] act_data;
  logic [SW-1:0] step;
  logic          arr_we;
  logic [AW-1:0] arr_waddr;
  logic [DW-1:0] arr_wdata;

  assign cmd_ready = !busy;

  nvm_prog_ctrl #(
    .AW(AW), .DW(DW), .T_WORD(T_WORD), .T_ALL(T_ALL), .T_WRALL(T_WRALL), .SW(SW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .prog_en(prog_en),
    .act_op(act_op), .act_addr(act_addr), .act_data(act_data), .step(step)
  );

  nvm_prog_wgen #(.AW(AW), .DW(DW), .SW(SW)) u_wgen (
    .busy(busy), .act_op(act_op), .act_addr(act_addr), .act_data(act_data),
    .step(step), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata)
  );

  nvm_prog_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/nvm_prog_seq_chk.sv
module nvm_prog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_op,
  input logic       cmd_ready,
  input logic       busy,
  input logic       prog_en,
  input logic       we
);
  logic take, take_prog;
  assign take      = cmd_valid && cmd_ready;
  assign take_prog = take && (cmd_op >= 3'd3) && (cmd_op <= 3'd6);

  // R1
  locked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_prog && !prog_en) |=> !busy);

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_prog && prog_en) |=> busy);

  // R8
  lock_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (cmd_op == 3'd1 || cmd_op == 3'd2)) |=> !busy);

  // R2
  unlock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_en) |-> $past(take && cmd_op == 3'd2));

  // R9
  busy_lock_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(prog_en));

  // R9
  write_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> busy);
endmodule

bind nvm_prog_seq nvm_prog_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_ready(cmd_ready), .busy(busy), .prog_en(prog_en), .we(arr_we)
);

// File: tb/sim_nvm_prog_seq.sv
module sim_nvm_prog_seq;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int T_WORD = 100;
  localparam int T_ALL = 300;
  localparam int T_WRALL = 750;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic cmd_ready, busy;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  logic [DW-1:0] exp_q[$];
  int            due_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;

  nvm_prog_seq #(.AW(AW), .DW(DW), .T_WORD(T_WORD), .T_ALL(T_ALL), .T_WRALL(T_WRALL)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results from the scoreboard
  always @(negedge clk) begin
    if (exp_q.size() != 0 && due_q[0] <= cyc) begin
      check(rd_data === exp_q[0], tag_q[0], int'(rd_data), int'(exp_q[0]));
      void'(exp_q.pop_front());
      void'(due_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
    @(posedge clk); #2;
    rd_addr = a;
    exp_q.push_back(e);
    due_q.push_back(cyc + 1);
    tag_q.push_back(tag);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(posedge clk); #2;
    cmd_valid = 1'b0;
  endtask

  task automatic send_timed(input logic [2:0] op, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input int t, input string tag);
    send(op, a, d);
    check(busy === 1'b1, {tag, " busy first"}, int'(busy), 1);
    repeat (t - 1) @(posedge clk);
    #2;
    check(busy === 1'b1, {tag, " busy last"}, int'(busy), 1);
    @(posedge clk); #2;
    check(busy === 1'b0, {tag, " busy end"}, int'(busy), 0);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic no_cycle(input logic [2:0] op, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input string tag);
    send(op, a, d);
    check(busy === 1'b0, tag, int'(busy), 0);
    repeat (3) @(posedge clk);
    #2;
    check(busy === 1'b0, tag, int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "reset busy", int'(busy), 0);
    check(cmd_ready === 1'b1, "R9 reset ready", int'(cmd_ready), 1);

    // R1: locked after reset, write and erase-all dropped
    no_cycle(3'd5, 8'd3, 8'h00, "R1 write locked");
    no_cycle(3'd4, 8'd0, 8'h00, "R1 erase-all locked");
    // R8 lock commands never start a cycle; R10 no-ops
    no_cycle(3'd1, 8'd0, 8'h00, "R8 unlock no busy");
    no_cycle(3'd0, 8'd0, 8'h00, "R10 nop");
    no_cycle(3'd7, 8'd0, 8'h00, "R10 reserved");

    // R5 / R8 erase-all
    send_timed(3'd4, 8'd0, 8'h00, T_ALL, "R8 erase-all");
    rd(8'd0, 8'hFF, "R5 word0");
    rd(8'd77, 8'hFF, "R5 word77");
    rd(8'd255, 8'hFF, "R5 word255");
    drain();

    // R6 / R8 single write
    send_timed(3'd5, 8'd3, 8'h5A, T_WORD, "R8 write");
    rd(8'd3, 8'h5A, "R6 write 5A");
    send_timed(3'd5, 8'd4, 8'h11, T_WORD, "R8 write2");
    send_timed(3'd5, 8'd3, 8'hA5, T_WORD, "R8 write3");
    rd(8'd3, 8'hA5, "R6 auto-erase overwrite");
    drain();

    // R4 single erase
    send_timed(3'd3, 8'd3, 8'h00, T_WORD, "R8 erase");
    rd(8'd3, 8'hFF, "R4 erased word");
    rd(8'd4, 8'h11, "R4 neighbour kept");
    drain();

    // R9 command during busy refused
    send(3'd5, 8'd5, 8'h66);
    check(cmd_ready === 1'b0, "R9 ready low in cycle", int'(cmd_ready), 0);
    send(3'd5, 8'd9, 8'h22);
    send(3'd2, 8'd0, 8'h00);
    wait_idle();
    rd(8'd5, 8'h66, "R6 write5");
    rd(8'd9, 8'hFF, "R9 refused write");
    drain();

    // R7 / R8 write-all (lock command above was refused, still unlocked)
    send_timed(3'd6, 8'd0, 8'h3C, T_WRALL, "R8 write-all");
    rd(8'd0, 8'h3C, "R7 word0");
    rd(8'd128, 8'h3C, "R7 word128");
    rd(8'd255, 8'h3C, "R7 word255");
    drain();

    // R2 lock drops programming; R3 reads still served
    send(3'd2, 8'd0, 8'h00);
    no_cycle(3'd5, 8'd7, 8'h00, "R2 write after lock");
    no_cycle(3'd3, 8'd7, 8'h00, "R2 erase after lock");
    rd(8'd7, 8'h3C, "R3 read while locked");
    drain();

    // R2 / R11 reset relocks and keeps contents
    send(3'd1, 8'd0, 8'h00);
    @(posedge clk); #2 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    no_cycle(3'd5, 8'd7, 8'h00, "R2 write after reset");
    rd(8'd7, 8'h3C, "R11 contents kept");
    rd(8'd200, 8'h3C, "R11 contents kept 200");
    drain();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule